// File: doc/BRIEF.md
# Chip-Select Bus Timing Controller

This block runs single reads and writes on a simple strobe-based external memory bus. An internal requester presents one transfer at a time on a valid/ready port. The block latches the address, the write data and a 32-bit timing option word. It then drives chip select, output enable, write enable, address and write data with edges placed on a grid of half bus-clock cycles. The whole block runs on an internal clock at twice the bus rate. It generates the bus clock itself by toggling a register on every internal edge. One internal cycle is one "tick", which is half a bus cycle. Any quarter-cycle timing is rounded up to a whole tick.

The option word selects five timing controls. Bits are numbered with bit 0 as the most significant:

| Control | Bits | Effect |
|---|---|---|
| chip-select lag | 21–22 | delay from address to chip select |
| early negate | 20 | end write strobes early |
| wait count | 24–27 | number of wait states |
| relaxed timing | 29 | stretch several timings |
| read hold extend | 30 | add idle time after reads |

All other bits are accepted and ignored. A bypass input delays every bus output by one tick, so outputs launch on falling bus-clock edges. Read data is still taken on a rising edge. A bank enable input stands in for the address match.

The controller has four states:

| State | Meaning | Leaves when | Goes to |
|---|---|---|---|
| ST_IDLE | ready for a request | a request is accepted | ST_SYNC |
| ST_SYNC | waiting for the bus clock to be low | bus clock is low | ST_ACTIVE (tick 0 starts in the high half of the bus clock) |
| ST_ACTIVE | counting ticks | the run length is reached | ST_ACK |
| ST_ACK | completion cycle | always, after one cycle | ST_IDLE |

Top module: `extbus_cs_timer`

## Requirements
- R1: After reset, ready is 1 and the bus clock is 0. Ack, chip select, output enable, write enable, address, write data, data drive and read data are all 0.
- R2: A request is taken on an edge where valid, bank enable and ready are all 1. A valid request while bank enable is 0 has no effect. Ready stays 0 from acceptance through the ack cycle. Ack is high for exactly one cycle, and ready returns in the cycle after it.
- R3: The bus clock output toggles on every internal edge. Tick 0 of every transfer falls in a cycle where the bus clock is 1.
- R4: The option word is decoded with bit 0 as the MSB, so vector index = 31 − bit:
  - chip-select lag = bits 21–22
  - early negate = bit 20
  - wait count = bits 24–27
  - relaxed timing = bit 29
  - read hold extend = bit 30
- R5: Let N = (lag ≠ 00).
  - Chip select asserts at tick CS_ON, where CS_ON = 0 if N is false, 1 if N is true, and 3 if N is true and relaxed timing is set.
  - The strobe (OE or WE) asserts at ST_ON = CS_ON + (N ? 1 : 0).
- R6: The strobe length is 2 + 2·W ticks, with W = wait count, or 2·wait count under relaxed timing. OE_OFF = ST_ON + 2 + 2W. On reads, output enable and chip select are 1 for ticks in [ST_ON, OE_OFF) and [CS_ON, OE_OFF).
- R7: Writes end WE early.
  - WE_OFF = OE_OFF − E, where E = 2 under relaxed timing, else 1 if early negate is set, else 0. WE_OFF is never below ST_ON + 1.
  - Chip select ends at WE_OFF when N is true, and at OE_OFF otherwise.
- R8: A write ends at tick OE_OFF.
  - A read ends at OE_OFF + 1 + H. H = 0 normally. With read hold extend set, H = 2, or 4 when relaxed timing is also set.
  - Ack follows the last tick of the run, where run length = end + bypass.
- R9: Address is driven for ticks [0, end). On writes, write data and its drive enable are held for ticks [0, end). Both read 0 outside a transfer.
- R10: In bypass mode every bus output at tick t equals the normal-mode value at tick t−1. Nothing is driven at tick 0.
- R11: Read data is captured at the edge that starts tick CAP, where CAP is the largest even number below the visible OE negation tick (OE_OFF + bypass). The captured value is held on rdata until the next read.
- R12: Output enable and write enable are never 1 together. Either strobe is 1 only while chip select is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | internal clock at twice the bus rate |
| rst_ni | input | 1 | asynchronous active-low reset |
| bypass_i | input | 1 | launch bus outputs one tick late (sampled at acceptance) |
| bank_en_i | input | 1 | request targets this bank |
| opt_i | input | 32 | timing option word (sampled at acceptance) |
| req_valid_i | input | 1 | request present |
| req_write_i | input | 1 | 1 = write, 0 = read |
| req_addr_i | input | ADDR_W | transfer address |
| req_wdata_i | input | DATA_W | write data |
| req_ready_o | output | 1 | controller idle, request can be taken |
| ack_o | output | 1 | one-cycle completion pulse |
| rdata_o | output | DATA_W | last captured read data |
| bclk_o | output | 1 | bus clock |
| bus_addr_o | output | ADDR_W | bus address |
| bus_wdata_o | output | DATA_W | bus write data |
| bus_wdata_oe_o | output | 1 | write data drive enable |
| bus_cs_o | output | 1 | chip select, active high |
| bus_oe_o | output | 1 | output enable, active high |
| bus_we_o | output | 1 | write enable, active high |
| bus_rdata_i | input | DATA_W | read data from the bus |

## Verification
The assertions check the relations that hold in every cycle:
- the ack pulse lasts one cycle, and ready is low during it;
- ready falls after an acceptance, and stays high when a request arrives without bank enable;
- the bus clock alternates on every edge;
- OE and WE are exclusive, and each is covered by chip select;
- write data is driven whenever write enable is.

The exact tick of each strobe edge depends on the option fields, the direction and bypass. Only the bench's reference model can show those positions, along with the end tick, the read capture edge, and correct field decoding. It compares all of these against its model in every cycle, across all lag codes, both relaxed settings, wait counts 0, 5 and 15, reads and writes, and both launch modes.

// File: rtl/extbus_cs_pkg.sv
package extbus_cs_pkg;
    // Wait-count field width is fixed by the option word layout.
    localparam int SCY_W     = 4;
    localparam int MAX_WAIT  = 2 * ((1 << SCY_W) - 1);
    // Longest run: lag 3 + 1, strobe 2 + 2*MAX_WAIT, read hold 1 + 4, bypass 1.
    localparam int MAX_TICKS = 4 + 2 + 2 * MAX_WAIT + 5 + 1;
    localparam int TICK_W    = $clog2(MAX_TICKS + 1);

    // Vector indices of option fields (MSB is bit 0, index = 31 - bit).
    localparam int POS_NEG_EARLY = 31 - 20;
    localparam int POS_LAG_LO    = 31 - 22;
    localparam int POS_WAIT_LO   = 31 - 27;
    localparam int POS_RELAX     = 31 - 29;
    localparam int POS_HOLD_EXT  = 31 - 30;

    typedef logic [TICK_W-1:0] tick_t;

    typedef struct packed {
        logic [1:0]       cs_lag;
        logic             neg_early;
        logic [SCY_W-1:0] wait_cnt;
        logic             relax;
        logic             rd_hold_ext;
    } cs_opt_t;

    typedef struct packed {
        logic cs;
        logic oe;
        logic we;
        logic drv;
        logic wdrv;
    } strobe_t;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SYNC,
        ST_ACTIVE,
        ST_ACK
    } xfer_state_e;
endpackage

// File: rtl/cs_timing_calc.sv
module cs_timing_calc
    import extbus_cs_pkg::*;
(
    input  cs_opt_t opt_i,
    input  logic    is_wr_i,
    input  logic    byp_i,
    output tick_t   cs_on_o,
    output tick_t   st_on_o,
    output tick_t   we_off_o,
    output tick_t   cs_off_o,
    output tick_t   oe_off_o,
    output tick_t   end_o,
    output tick_t   run_len_o,
    output tick_t   cap_o
);
    logic  lag_nz;
    tick_t waits, early, hold, vis_off, cut;

    always_comb begin
        lag_nz   = |opt_i.cs_lag;
        waits    = opt_i.relax ? tick_t'({opt_i.wait_cnt, 1'b0}) : tick_t'(opt_i.wait_cnt);
        cs_on_o  = lag_nz ? (opt_i.relax ? tick_t'(3) : tick_t'(1)) : tick_t'(0);
        st_on_o  = cs_on_o + tick_t'(lag_nz);
        oe_off_o = st_on_o + tick_t'(2) + (waits << 1);
        early    = opt_i.relax ? tick_t'(2) : (opt_i.neg_early ? tick_t'(1) : tick_t'(0));
        cut      = oe_off_o - early;
        we_off_o = (cut > st_on_o) ? cut : st_on_o + tick_t'(1);
        cs_off_o = (is_wr_i && lag_nz) ? we_off_o : oe_off_o;
        hold     = opt_i.rd_hold_ext ? (opt_i.relax ? tick_t'(4) : tick_t'(2)) : tick_t'(0);
        end_o    = is_wr_i ? oe_off_o : oe_off_o + tick_t'(1) + hold;
        run_len_o = end_o + tick_t'(byp_i);
        vis_off  = oe_off_o + tick_t'(byp_i);
        cap_o    = (vis_off - tick_t'(1)) & ~tick_t'(1);
    end
endmodule

// File: rtl/cs_strobe_gen.sv
module cs_strobe_gen
    import extbus_cs_pkg::*;
(
    input  logic    active_i,
    input  logic    is_wr_i,
    input  tick_t   t_i,
    input  tick_t   cs_on_i,
    input  tick_t   st_on_i,
    input  tick_t   we_off_i,
    input  tick_t   cs_off_i,
    input  tick_t   oe_off_i,
    input  tick_t   end_i,
    output strobe_t raw_o
);
    always_comb begin
        raw_o.cs   = active_i && (t_i >= cs_on_i) && (t_i < cs_off_i);
        raw_o.oe   = active_i && !is_wr_i && (t_i >= st_on_i) && (t_i < oe_off_i);
        raw_o.we   = active_i && is_wr_i && (t_i >= st_on_i) && (t_i < we_off_i);
        raw_o.drv  = active_i && (t_i < end_i);
        raw_o.wdrv = active_i && is_wr_i && (t_i < end_i);
    end
endmodule

// File: rtl/cs_launch_stage.sv
module cs_launch_stage
    import extbus_cs_pkg::*;
(
    input  logic    clk_i,
    input  logic    rst_ni,
    input  logic    byp_i,
    input  strobe_t raw_i,
    output strobe_t out_o
);
    strobe_t dly_q;

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            dly_q <= '0;
        end else begin
            dly_q <= raw_i;
        end
    end

    assign out_o = byp_i ? dly_q : raw_i;
endmodule

// File: rtl/extbus_cs_timer.sv
module extbus_cs_timer
    import extbus_cs_pkg::*;
#(
    parameter int ADDR_W = 24,
    parameter int DATA_W = 16
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              bypass_i,
    input  logic              bank_en_i,
    input  logic [31:0]       opt_i,
    input  logic              req_valid_i,
    input  logic              req_write_i,
    input  logic [ADDR_W-1:0] req_addr_i,
    input  logic [DATA_W-1:0] req_wdata_i,
    output logic              req_ready_o,
    output logic              ack_o,
    output logic [DATA_W-1:0] rdata_o,
    output logic              bclk_o,
    output logic [ADDR_W-1:0] bus_addr_o,
    output logic [DATA_W-1:0] bus_wdata_o,
    output logic              bus_wdata_oe_o,
    output logic              bus_cs_o,
    output logic              bus_oe_o,
    output logic              bus_we_o,
    input  logic [DATA_W-1:0] bus_rdata_i
);
    xfer_state_e       state_q, state_d;
    tick_t             t_q, t_d;
    cs_opt_t           opt_q;
    logic              wr_q, byp_q, bclk_q;
    logic [ADDR_W-1:0] addr_q;
    logic [DATA_W-1:0] wdata_q, rdata_q;
    logic              accept, capture;
    tick_t             cs_on, st_on, we_off, cs_off, oe_off, end_t, run_len, cap_t;
    strobe_t           raw, launched;

    // Option bits with no timing role here.
    logic unused_opt_bits;
    assign unused_opt_bits = ^{opt_i[31:12], opt_i[8], opt_i[3], opt_i[0]};

    assign accept = req_valid_i && bank_en_i && (state_q == ST_IDLE);

    cs_timing_calc u_calc (
        .opt_i    (opt_q),
        .is_wr_i  (wr_q),
        .byp_i    (byp_q),
        .cs_on_o  (cs_on),
        .st_on_o  (st_on),
        .we_off_o (we_off),
        .cs_off_o (cs_off),
        .oe_off_o (oe_off),
        .end_o    (end_t),
        .run_len_o(run_len),
        .cap_o    (cap_t)
    );

    cs_strobe_gen u_strobe (
        .active_i (state_q == ST_ACTIVE),
        .is_wr_i  (wr_q),
        .t_i      (t_q),
        .cs_on_i  (cs_on),
        .st_on_i  (st_on),
        .we_off_i (we_off),
        .cs_off_i (cs_off),
        .oe_off_i (oe_off),
        .end_i    (end_t),
        .raw_o    (raw)
    );

    cs_launch_stage u_launch (
        .clk_i  (clk_i),
        .rst_ni (rst_ni),
        .byp_i  (byp_q),
        .raw_i  (raw),
        .out_o  (launched)
    );

    // State register.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            state_q <= ST_IDLE;
            t_q     <= '0;
        end else begin
            state_q <= state_d;
            t_q     <= t_d;
        end
    end

    // Next-state logic.
    always_comb begin
        state_d = state_q;
        t_d     = t_q;
        unique case (state_q)
            ST_IDLE:   if (accept) state_d = ST_SYNC;
            ST_SYNC: begin
                if (!bclk_q) begin
                    state_d = ST_ACTIVE;
                    t_d     = '0;
                end
            end
            ST_ACTIVE: begin
                if (t_q == run_len - tick_t'(1)) state_d = ST_ACK;
                else                             t_d = t_q + tick_t'(1);
            end
            ST_ACK:    state_d = ST_IDLE;
            default:   state_d = ST_IDLE;
        endcase
    end

    assign capture = !wr_q &&
                     (((state_q == ST_SYNC) && !bclk_q && (cap_t == '0)) ||
                      ((state_q == ST_ACTIVE) && (t_q + tick_t'(1) == cap_t)));

    // Request latch, bus clock and read capture.
    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            opt_q   <= '0;
            wr_q    <= 1'b0;
            byp_q   <= 1'b0;
            addr_q  <= '0;
            wdata_q <= '0;
            rdata_q <= '0;
            bclk_q  <= 1'b0;
        end else begin
            bclk_q <= !bclk_q;
            if (accept) begin
                opt_q.cs_lag      <= opt_i[POS_LAG_LO +: 2];
                opt_q.neg_early   <= opt_i[POS_NEG_EARLY];
                opt_q.wait_cnt    <= opt_i[POS_WAIT_LO +: SCY_W];
                opt_q.relax       <= opt_i[POS_RELAX];
                opt_q.rd_hold_ext <= opt_i[POS_HOLD_EXT];
                wr_q    <= req_write_i;
                byp_q   <= bypass_i;
                addr_q  <= req_addr_i;
                wdata_q <= req_wdata_i;
            end
            if (capture) rdata_q <= bus_rdata_i;
        end
    end

    // Outputs.
    always_comb begin
        req_ready_o    = (state_q == ST_IDLE);
        ack_o          = (state_q == ST_ACK);
        rdata_o        = rdata_q;
        bclk_o         = bclk_q;
        bus_cs_o       = launched.cs;
        bus_oe_o       = launched.oe;
        bus_we_o       = launched.we;
        bus_wdata_oe_o = launched.wdrv;
        bus_addr_o     = launched.drv  ? addr_q  : '0;
        bus_wdata_o    = launched.wdrv ? wdata_q : '0;
    end
endmodule

// File: rtl/extbus_cs_timer_chk.sv
module extbus_cs_timer_chk (
    input logic clk_i,
    input logic rst_ni,
    input logic req_valid_i,
    input logic bank_en_i,
    input logic req_ready_o,
    input logic ack_o,
    input logic bclk_o,
    input logic bus_cs_o,
    input logic bus_oe_o,
    input logic bus_we_o,
    input logic bus_wdata_oe_o
);
    p_ack_single_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |=> !ack_o);
    p_ack_not_ready_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ack_o |-> !req_ready_o);
    p_accept_busy_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_valid_i && bank_en_i && req_ready_o) |=> !req_ready_o);
    p_no_bank_idle_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (req_ready_o && !bank_en_i) |=> req_ready_o);
    p_bclk_rise_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !bclk_o |=> bclk_o);
    p_bclk_fall_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bclk_o |=> !bclk_o);
    p_strobe_excl_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !(bus_oe_o && bus_we_o));
    p_strobe_in_cs_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (bus_oe_o || bus_we_o) |-> bus_cs_o);
    p_we_has_data_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
        bus_we_o |-> bus_wdata_oe_o);
    p_idle_quiet_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_ready_o |-> !bus_cs_o);
endmodule

bind extbus_cs_timer extbus_cs_timer_chk chk_i (
    .clk_i          (clk_i),
    .rst_ni         (rst_ni),
    .req_valid_i    (req_valid_i),
    .bank_en_i      (bank_en_i),
    .req_ready_o    (req_ready_o),
    .ack_o          (ack_o),
    .bclk_o         (bclk_o),
    .bus_cs_o       (bus_cs_o),
    .bus_oe_o       (bus_oe_o),
    .bus_we_o       (bus_we_o),
    .bus_wdata_oe_o (bus_wdata_oe_o)
);

// File: tb/extbus_cs_timer_tb_top.sv
module extbus_cs_timer_tb_top;
    localparam int AW = 24;
    localparam int DW = 16;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          bypass = 1'b0;
    logic          bank_en = 1'b0;
    logic [31:0]   opt = '0;
    logic          req_valid = 1'b0;
    logic          req_write = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic          req_ready, ack, bclk, wdata_oe, cs, oe, we;
    logic [DW-1:0] rdata, bus_wdata;
    logic [DW-1:0] bus_rdata = 16'h1234;
    logic [AW-1:0] bus_addr;

    int checks = 0;
    int fails = 0;
    bit run_chk = 0;
    bit done = 0;

    always #5 clk = ~clk;

    extbus_cs_timer #(.ADDR_W(AW), .DATA_W(DW)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .bypass_i(bypass), .bank_en_i(bank_en),
        .opt_i(opt), .req_valid_i(req_valid), .req_write_i(req_write),
        .req_addr_i(req_addr), .req_wdata_i(req_wdata), .req_ready_o(req_ready),
        .ack_o(ack), .rdata_o(rdata), .bclk_o(bclk), .bus_addr_o(bus_addr),
        .bus_wdata_o(bus_wdata), .bus_wdata_oe_o(wdata_oe), .bus_cs_o(cs),
        .bus_oe_o(oe), .bus_we_o(we), .bus_rdata_i(bus_rdata)
    );

    // Read data changes every internal cycle so the capture edge is visible.
    always @(negedge clk) bus_rdata <= bus_rdata + 16'h1357;

    // ---------------- reference model ----------------
    int m_st = 0;   // 0 idle, 1 sync, 2 active, 3 ack
    int m_t = 0;
    bit m_bclk = 0, m_wr = 0, m_byp = 0;
    logic [DW-1:0] m_rdata = '0, m_wdata = '0;
    logic [AW-1:0] m_addr = '0;
    int e_cson, e_ston, e_weoff, e_csoff, e_stoff, e_end, e_n, e_cap;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_st = 0; m_t = 0; m_bclk = 0; m_rdata = '0;
        end else begin
            case (m_st)
                0: if (req_valid && bank_en) begin
                    int lag, neg, wc, rlx, hx, w, early;
                    bit nz;
                    // R4: MSB-first numbering, vector index = 31 - bit
                    lag = opt[10:9]; neg = opt[11]; wc = opt[7:4];
                    rlx = opt[2];    hx  = opt[1];
                    m_wr = req_write; m_byp = bypass;
                    m_addr = req_addr; m_wdata = req_wdata;
                    nz = (lag != 0);
                    w = rlx ? 2 * wc : wc;
                    e_cson = nz ? (rlx ? 3 : 1) : 0;
                    e_ston = e_cson + (nz ? 1 : 0);
                    e_stoff = e_ston + 2 + 2 * w;
                    early = rlx ? 2 : (neg ? 1 : 0);
                    e_weoff = e_stoff - early;
                    if (e_weoff < e_ston + 1) e_weoff = e_ston + 1;
                    e_csoff = (m_wr && nz) ? e_weoff : e_stoff;
                    e_end = m_wr ? e_stoff : e_stoff + 1 + (hx ? (rlx ? 4 : 2) : 0);
                    e_n = e_end + (m_byp ? 1 : 0);
                    e_cap = ((e_stoff + (m_byp ? 1 : 0) - 1) / 2) * 2;
                    m_st = 1;
                end
                1: if (!m_bclk) begin
                    if (!m_wr && e_cap == 0) m_rdata = bus_rdata;
                    m_st = 2; m_t = 0;
                end
                2: begin
                    if (!m_wr && m_t + 1 == e_cap) m_rdata = bus_rdata;
                    if (m_t + 1 == e_n) m_st = 3;
                    else m_t = m_t + 1;
                end
                default: m_st = 0;
            endcase
            m_bclk = !m_bclk;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s%s actual=%0h expected=%0h", m_byp ? "R10/" : "", tag, act, exp);
        end
    endtask

    // Per-cycle comparison, sampled away from the active edge.
    always @(negedge clk) begin
        if (rst_n && run_chk) begin
            int tt;
            bit act, ecs, eoe, ewe, edrv, ewdrv;
            tt = m_byp ? m_t - 1 : m_t;     // R10: one-tick launch delay
            act = (m_st == 2) && (tt >= 0);
            ecs = act && tt >= e_cson && tt < e_csoff;
            eoe = act && !m_wr && tt >= e_ston && tt < e_stoff;
            ewe = act && m_wr && tt >= e_ston && tt < e_weoff;
            edrv = act && tt < e_end;
            ewdrv = edrv && m_wr;
            chk(bclk == m_bclk, "R3 bclk", bclk, m_bclk);
            chk(req_ready == (m_st == 0), "R2 ready", req_ready, m_st == 0);
            chk(ack == (m_st == 3), "R2/R8 ack", ack, m_st == 3);
            chk(cs == ecs, "R4/R5 cs", cs, ecs);
            chk(oe == eoe, "R6 oe", oe, eoe);
            chk(we == ewe, "R7 we", we, ewe);
            chk(bus_addr == (edrv ? m_addr : '0), "R9 addr", bus_addr, edrv ? m_addr : '0);
            chk(wdata_oe == ewdrv, "R9 wdata_oe", wdata_oe, ewdrv);
            chk(bus_wdata == (ewdrv ? m_wdata : '0), "R9 wdata", bus_wdata, ewdrv ? m_wdata : '0);
            chk(rdata == m_rdata, "R11 rdata", rdata, m_rdata);
            chk(!(oe && we) && (!(oe || we) || cs), "R12 strobe cover", {oe, we, cs}, 0);
        end
    end

    function automatic logic [31:0] build_opt(int lag, int neg, int wc, int rlx, int hx, bit junk);
        logic [31:0] o;
        o = junk ? 32'hFFFF_F109 : 32'h0;   // unrelated bits set or clear
        o[10:9] = lag[1:0];
        o[11] = neg[0];
        o[7:4] = wc[3:0];
        o[2] = rlx[0];
        o[1] = hx[0];
        return o;
    endfunction

    task automatic do_xfer(input logic [31:0] o, input bit wr, input bit byp,
                           input logic [AW-1:0] a, input logic [DW-1:0] d);
        while (!req_ready) @(negedge clk);
        opt = o; req_write = wr; bypass = byp; req_addr = a; req_wdata = d;
        bank_en = 1'b1; req_valid = 1'b1;
        @(negedge clk);
        req_valid = 1'b0;
        while (!req_ready) @(negedge clk);
        @(negedge clk);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R1: reset values
        chk(req_ready == 1'b1, "R1 ready", req_ready, 1);
        chk(ack == 1'b0 && bclk == 1'b0, "R1 ack/bclk", {ack, bclk}, 0);
        chk({cs, oe, we, wdata_oe} == 4'b0, "R1 strobes", {cs, oe, we, wdata_oe}, 0);
        chk(bus_addr == '0 && bus_wdata == '0 && rdata == '0, "R1 data", bus_addr, 0);
        rst_n = 1'b1;
        run_chk = 1;
        // R2: a request without bank enable is ignored
        opt = build_opt(3, 1, 15, 1, 1, 1);
        req_valid = 1'b1; bank_en = 1'b0;
        repeat (4) begin
            @(negedge clk);
            chk(req_ready == 1'b1 && cs == 1'b0 && bus_addr == '0, "R2 no-bank ignored",
                {req_ready, cs}, 2'b10);
        end
        req_valid = 1'b0;
        @(negedge clk);
        for (int bp = 0; bp < 2; bp++)
            for (int wr = 0; wr < 2; wr++)
                for (int rl = 0; rl < 2; rl++)
                    for (int lg = 0; lg < 4; lg++)
                        for (int si = 0; si < 3; si++) begin
                            int wc;
                            wc = (si == 0) ? 0 : ((si == 1) ? 15 : 5);
                            do_xfer(build_opt(lg, (lg + si) % 2, wc, rl, (lg + si + 1) % 2, si[0]),
                                    wr[0], bp[0], AW'(24'hA5_0000 + lg * 16 + si),
                                    DW'(16'hC000 + rl * 256 + lg * 8 + si));
                        end
        done = 1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog expired: actual=hung expected=finished");
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end
endmodule